// File: doc/BRIEF.md
# Ethernet MAC Control and Wakeup Register

This block is the control register of an Ethernet MAC. It stores the enable, timestamp-mode, sleep and magic-packet-arm bits. It also has a self-clearing reset command bit. From these it drives the datapath enable and a one-cycle reset pulse for the DMA, descriptor and FIFO pointer logic. When the MAC is switched off in the middle of a transmission, it also sends an abort request to the transmitter. On abort, the transmitter appends a corrupted CRC and does not write back the descriptor of that frame.

Two hardware events act on the register. A bus-error event turns the enable off without software. A magic-packet pulse from the frame parser sets a sticky wakeup interrupt flag, but only while both sleep and magic arm are set. Software clears the flag by writing 1 to it. Software reaches both registers through a plain single-cycle write port and a combinational read port.

Top module: `mac_wake_ctl`

## Requirements
- R1: The control register sits at address 0. Its bit 0 is the reset command, bit 1 the MAC enable, bit 2 magic arm, bit 3 sleep and bit 4 timestamp mode. A write stores bits 1 to 4, which read back in place. All bits above 4 read as 0.
- R2: The reset command bit always reads 0. Writing 1 to it forces the enable to 0 in the next cycle, even if bit 1 of the same write is 1. It also raises `dma_rst_o` for exactly the next cycle.
- R3: `bus_err_i` high in a cycle makes `mac_en_o` 0 in the next cycle. This overrides a write in the same cycle that sets the enable.
- R4: `magic_arm_o` equals sleep AND magic arm, taken from the stored bits 3 and 2.
- R5: `magic_seen_i` high while `magic_arm_o` is high sets the wakeup flag in the next cycle. `magic_seen_i` has no effect on the flag while `magic_arm_o` is low.
- R6: The wakeup flag is bit 0 of address 1 and also drives `wake_irq_o`. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged. A detection in the same cycle as the clear wins, and the flag stays set.
- R7: When the enable goes from 1 to 0, for any cause, `dma_rst_o` is high for exactly one cycle. That cycle is the first one in which `mac_en_o` reads 0.
- R8: `tx_abort_o` is high for one cycle, together with that `dma_rst_o`, only when `tx_busy_i` was high in the cycle that turned the enable off.
- R9: After reset, every stored bit, the wakeup flag and all pulse outputs are 0.
- R10: A read of any address other than 0 or 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | AW | Register address for read and write |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Combinational read data for `addr` |
| bus_err_i | input | 1 | Bus-error event, kills the enable |
| magic_seen_i | input | 1 | Magic packet recognised by the parser |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| mac_en_o | output | 1 | Datapath enable (reception stops when low) |
| ts_mode_o | output | 1 | 0 legacy descriptors, 1 enhanced timestamping |
| sleep_o | output | 1 | Sleep mode |
| magic_arm_o | output | 1 | Magic-packet detection active |
| wake_irq_o | output | 1 | Wakeup interrupt flag |
| dma_rst_o | output | 1 | One-cycle reset of DMA, descriptor and FIFO pointers |
| tx_abort_o | output | 1 | One-cycle request to end the current frame with a bad CRC and skip write-back |

## Verification
The assertions expect every input to hold a known value from reset onward and to change only between clock edges. They allow any overlap of events: a bus error, a reset command, a clear of the flag and a detection may all land in the same cycle. The stimulus uses that freedom on purpose. Directed sequences put the reset command against a write that sets the enable, a bus error against a write that sets the enable, and a clear against a detection. A long random phase then drives every input, with one address held out of the map, so that no combination is excluded.

// File: rtl/mac_wake_pkg.sv
package mac_wake_pkg;
   localparam int unsigned BIT_RST   = 0;
   localparam int unsigned BIT_EN    = 1;
   localparam int unsigned BIT_ARM   = 2;
   localparam int unsigned BIT_SLEEP = 3;
   localparam int unsigned BIT_TS    = 4;
   localparam int unsigned NBITS     = 5;

   typedef struct packed {
      logic ts;
      logic sleep;
      logic arm;
      logic en;
   } ctl_bits_t;
endpackage

// File: rtl/mac_wake_ctlreg.sv
module mac_wake_ctlreg
   import mac_wake_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic [NBITS-1:0] wbits,
   input  logic             bus_err,
   output ctl_bits_t        ctl_q,
   output logic             en_drop,
   output logic             rst_cmd
);
   ctl_bits_t ctl_d;

   always_comb begin
      ctl_d = ctl_q;
      if (wr_ctl) begin
         ctl_d.en    = wbits[BIT_EN] & ~wbits[BIT_RST];
         ctl_d.arm   = wbits[BIT_ARM];
         ctl_d.sleep = wbits[BIT_SLEEP];
         ctl_d.ts    = wbits[BIT_TS];
      end
      if (bus_err) ctl_d.en = 1'b0;
   end

   assign en_drop = ctl_q.en & ~ctl_d.en;
   assign rst_cmd = wr_ctl & wbits[BIT_RST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
   end

   a_r3_buserr_kills_en: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> !ctl_q.en);
   a_r2_rstcmd_kills_en: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && wbits[BIT_RST]) |=> !ctl_q.en);
endmodule

// File: rtl/mac_wake_pulse.sv
module mac_wake_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic en_drop,
   input  logic rst_cmd,
   input  logic tx_busy,
   input  logic en_now,
   output logic dma_rst,
   output logic tx_abort
);
   logic drop_q, cmd_q, abort_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop_q  <= 1'b0;
         cmd_q   <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         drop_q  <= en_drop;
         cmd_q   <= rst_cmd;
         abort_q <= en_drop & tx_busy;
      end
   end

   assign dma_rst  = drop_q | cmd_q;
   assign tx_abort = abort_q;

   a_r7_fall_gives_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_now) |-> dma_rst);
   a_r8_abort_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> (dma_rst && !en_now));
   a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort);
endmodule

// File: rtl/mac_wake_flag.sv
module mac_wake_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic seen,
   input  logic armed,
   input  logic clr,
   output logic flag
);
   logic hit;
   assign hit = seen & armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   a_r5_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && armed) |=> flag);
   a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(seen && armed)) |=> !flag);
   a_r5_no_rise_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(seen && armed));
endmodule

// File: rtl/mac_wake_ctl.sv
module mac_wake_ctl
   import mac_wake_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 4,
   parameter int unsigned CTL_ADDR  = 0,
   parameter int unsigned WAKE_ADDR = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   input  logic          bus_err_i,
   input  logic          magic_seen_i,
   input  logic          tx_busy_i,
   output logic          mac_en_o,
   output logic          ts_mode_o,
   output logic          sleep_o,
   output logic          magic_arm_o,
   output logic          wake_irq_o,
   output logic          dma_rst_o,
   output logic          tx_abort_o
);
   localparam int unsigned PAD = DW - NBITS;
   localparam logic [AW-1:0] A_CTL  = AW'(CTL_ADDR);
   localparam logic [AW-1:0] A_WAKE = AW'(WAKE_ADDR);

   if (DW < NBITS) begin : g_dw_chk
      $error("DW too small for the control fields");
   end
   if (CTL_ADDR == WAKE_ADDR || CTL_ADDR >= (1 << AW) || WAKE_ADDR >= (1 << AW)) begin : g_addr_chk
      $error("register addresses overlap or do not fit AW");
   end

   if (PAD > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[DW-1:NBITS];
   end

   ctl_bits_t ctl_q;
   logic en_drop, rst_cmd, wr_ctl, wr_wake, flag;

   assign wr_ctl  = wr_en && (addr == A_CTL);
   assign wr_wake = wr_en && (addr == A_WAKE);

   mac_wake_ctlreg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (wr_ctl),
      .wbits   (wr_data[NBITS-1:0]),
      .bus_err (bus_err_i),
      .ctl_q   (ctl_q),
      .en_drop (en_drop),
      .rst_cmd (rst_cmd)
   );

   mac_wake_pulse u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_drop  (en_drop),
      .rst_cmd  (rst_cmd),
      .tx_busy  (tx_busy_i),
      .en_now   (ctl_q.en),
      .dma_rst  (dma_rst_o),
      .tx_abort (tx_abort_o)
   );

   mac_wake_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .seen  (magic_seen_i),
      .armed (magic_arm_o),
      .clr   (wr_wake & wr_data[0]),
      .flag  (flag)
   );

   assign mac_en_o    = ctl_q.en;
   assign ts_mode_o   = ctl_q.ts;
   assign sleep_o     = ctl_q.sleep;
   assign magic_arm_o = ctl_q.sleep & ctl_q.arm;
   assign wake_irq_o  = flag;

   always_comb begin
      rd_data = '0;
      if (addr == A_CTL) begin
         rd_data[BIT_EN]    = ctl_q.en;
         rd_data[BIT_ARM]   = ctl_q.arm;
         rd_data[BIT_SLEEP] = ctl_q.sleep;
         rd_data[BIT_TS]    = ctl_q.ts;
      end else if (addr == A_WAKE) begin
         rd_data[0] = flag;
      end
   end

   a_r2_rst_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BIT_RST] == ((addr == A_WAKE) && wake_irq_o));
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != A_CTL && addr != A_WAKE) |-> (rd_data == '0));
endmodule

// File: tb/mac_wake_ctl_tb.sv
`timescale 1ns/1ps
module mac_wake_ctl_tb;
   localparam int DW = 32;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic bus_err_i = 1'b0, magic_seen_i = 1'b0, tx_busy_i = 1'b0;
   logic mac_en_o, ts_mode_o, sleep_o, magic_arm_o, wake_irq_o, dma_rst_o, tx_abort_o;

   always #2 clk = ~clk;

   mac_wake_ctl #(.DW(DW), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .bus_err_i(bus_err_i), .magic_seen_i(magic_seen_i),
      .tx_busy_i(tx_busy_i), .mac_en_o(mac_en_o), .ts_mode_o(ts_mode_o),
      .sleep_o(sleep_o), .magic_arm_o(magic_arm_o), .wake_irq_o(wake_irq_o),
      .dma_rst_o(dma_rst_o), .tx_abort_o(tx_abort_o)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // reference state
   bit m_en, m_arm, m_slp, m_ts, m_wake, m_dma, m_abort;

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_rd();
      logic [DW-1:0] v = '0;
      if (addr == 0) v[4:0] = {m_ts, m_slp, m_arm, m_en, 1'b0};
      else if (addr == 1) v[0] = m_wake;
      return v;
   endfunction

   task automatic compare_all();
      chk("R1/R2/R10 rd_data", rd_data, exp_rd());
      chk("R2/R3 mac_en_o", {31'b0, mac_en_o}, {31'b0, m_en});
      chk("R1 ts_mode_o", {31'b0, ts_mode_o}, {31'b0, m_ts});
      chk("R1 sleep_o", {31'b0, sleep_o}, {31'b0, m_slp});
      chk("R4 magic_arm_o", {31'b0, magic_arm_o}, {31'b0, m_slp & m_arm});
      chk("R5/R6 wake_irq_o", {31'b0, wake_irq_o}, {31'b0, m_wake});
      chk("R7 dma_rst_o", {31'b0, dma_rst_o}, {31'b0, m_dma});
      chk("R8 tx_abort_o", {31'b0, tx_abort_o}, {31'b0, m_abort});
   endtask

   // drive at negedge, advance model at posedge, compare at next negedge
   task automatic cyc(input bit w, input int a, input int d, input bit be, input bit ms, input bit tb);
      bit en_n, wr0, wr1, fall;
      wr_en = w; addr = AW'(a); wr_data = DW'(d);
      bus_err_i = be; magic_seen_i = ms; tx_busy_i = tb;
      @(posedge clk);
      wr0 = w && a == 0;
      wr1 = w && a == 1;
      en_n = wr0 ? (d[1] && !d[0]) : m_en;
      if (be) en_n = 0;
      fall = m_en && !en_n;
      m_dma = fall || (wr0 && d[0]);
      m_abort = fall && tb;
      m_wake = (ms && m_slp && m_arm) || (m_wake && !(wr1 && d[0]));
      if (wr0) begin m_arm = d[2]; m_slp = d[3]; m_ts = d[4]; end
      m_en = en_n;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 reset rd ctl", rd_data, '0);
      chk("R9 reset outs", {25'b0, mac_en_o, ts_mode_o, sleep_o, magic_arm_o, wake_irq_o, dma_rst_o, tx_abort_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: store all fields
      cyc(1, 0, 32'hFFFF_FFFE, 0, 0, 0);
      chk("R1 readback full", rd_data, 32'h1E);
      // R8: drop enable while transmitting
      cyc(1, 0, 32'h0C, 0, 0, 1);
      chk("R8 abort pulse", {31'b0, tx_abort_o}, 1);
      chk("R7 dma pulse on fall", {31'b0, dma_rst_o}, 1);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R7 dma pulse single", {31'b0, dma_rst_o}, 0);
      // R2: reset cmd against enable set in same write
      cyc(1, 0, 32'h03, 0, 0, 0);
      chk("R2 en stays off", {31'b0, mac_en_o}, 0);
      chk("R2 rst bit reads 0", rd_data, 32'h0);
      chk("R2 dma pulse from rst", {31'b0, dma_rst_o}, 1);
      // R3: bus error against enable write
      cyc(1, 0, 32'h0E, 1, 0, 0);
      chk("R3 buserr wins", {31'b0, mac_en_o}, 0);
      cyc(1, 0, 32'h0E, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0);
      chk("R3 buserr kills en", {31'b0, mac_en_o}, 0);
      // R5: detection while armed (sleep=1, arm=1)
      cyc(0, 1, 0, 0, 1, 0);
      chk("R5 wake set", {31'b0, wake_irq_o}, 1);
      // R6: clear with simultaneous detection keeps flag
      cyc(1, 1, 1, 0, 1, 0);
      chk("R6 detect wins over clear", rd_data, 32'h1);
      cyc(1, 1, 0, 0, 0, 0);
      chk("R6 write 0 keeps", {31'b0, wake_irq_o}, 1);
      cyc(1, 1, 1, 0, 0, 0);
      chk("R6 clear", {31'b0, wake_irq_o}, 0);
      // R5: unarmed (sleep=0) detection ignored
      cyc(1, 0, 32'h04, 0, 0, 0);
      cyc(0, 1, 0, 0, 1, 0);
      chk("R5 unarmed ignored", rd_data, 32'h0);
      // R10: unmapped address
      cyc(0, 7, 0, 0, 0, 0);
      chk("R10 unmapped", rd_data, 32'h0);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         int a;
         a = ($urandom % 4 == 3) ? 5 : int'($urandom % 2);
         cyc(($urandom % 3) == 0, a, int'($urandom),
             ($urandom % 16) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule